// File: doc/BRIEF.md
# Sigma-Delta Counting Decimator

This block reduces the single-bit output of a first-order sigma-delta modulator to a signed conversion word. The comparator stream is sampled on an enable derived from the oversampling clock through a prescaler of 1, 2 or 4. A single up/down counter then runs over a fixed window of sampled ticks. Each 1 adds one and each 0 subtracts one, so the final count is proportional to the duty cycle of the stream.

At the end of the window the count is scaled so that a full-scale window maps to the edge of the 14-bit code range. The scaled count is packed into a 16-bit word with an overrange flag, a sign bit and a 14-bit magnitude. The word is stored in a holding register that stays static until the next conversion ends. An active-low busy output marks the conversion. A single-cycle start request begins a conversion and also captures the prescaler setting. The integrator, comparator and feedback DAC are outside the block.

Top module: `sdm_count_decim`

## Requirements
- R1: While reset is asserted and after it is released with no start request, busy_n is 1 and result is 16'h0000.
- R2: A start sampled high while busy_n is 1 drives busy_n to 0 from the next cycle. busy_n stays 0 for exactly D*N clock cycles, where N is CONV_TICKS and D is picked by div_sel at the start: 2'b00 gives 1, 2'b01 gives 2, and 2'b10 or 2'b11 gives 4.
- R3: Within a conversion, bit_in is sampled once every D clock cycles, on the D-th, 2D-th and later cycles after the start. The signed count c is the number of sampled ones minus the number of sampled zeros over the N samples.
- R4: The scaled magnitude is q = floor(|c| * ceil(2^30 / N) / 2^16). The result word holds the overrange flag in bit 15, set when q > 16383. It holds the sign in bit 14, set when c < 0. Bits 13:0 hold q, clamped to 16383 when overrange is set.
- R5: A window of all ones gives 16'hBFFF and a window of all zeros gives 16'hFFFF.
- R6: A start request made while busy_n is 0 has no effect: the conversion length and result are unchanged, and no new conversion follows.
- R7: result keeps its previous value during a conversion and changes only on the edge where busy_n returns to 1.
- R8: Changing div_sel during a conversion does not change that conversion's length.
- R9: A window with equal numbers of ones and zeros gives 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled each cycle |
| div_sel | input | 2 | Prescaler choice, captured with start |
| bit_in | input | 1 | Comparator bitstream |
| busy_n | output | 1 | Low while a conversion runs |
| result | output | 16 | Overrange, sign and 14-bit magnitude |

## Verification
A wrong prescaler phase or a wrong captured divide setting shows up as a busy_n low time that differs from D*N cycles. This is visible on the edge where busy_n should rise. A counter that drops, repeats or mis-signs a sample changes the latched word in the same cycle that busy_n rises. Patterns whose bit changes only every D cycles expose a sample taken at the wrong phase. A holding register that leaks intermediate state shows a result change while busy_n is still low.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

   typedef enum logic [1:0] {
      DIV_1  = 2'b00,
      DIV_2  = 2'b01,
      DIV_4  = 2'b10,
      DIV_4X = 2'b11
   } div_e;

   // terminal value of the prescaler phase counter for a divide mode
   function automatic logic [1:0] div_last(div_e m);
      case (m)
         DIV_1:   return 2'd0;
         DIV_2:   return 2'd1;
         default: return 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/sdm_prescale.sv
module sdm_prescale
   import sdm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  div_e mode,
   output logic tick
);

   logic [1:0] phase;
   logic [1:0] last_ph;

   assign last_ph = div_last(mode);
   assign tick    = run && (phase == last_ph);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (clr)
         phase <= '0;
      else if (run)
         phase <= (phase == last_ph) ? 2'd0 : phase + 2'd1;
   end

   // R2: with a divide above one, a tick is never followed directly by another
   a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clr && (last_ph != 2'd0)) |=> !tick);

endmodule

// File: rtl/sdm_updown.sv
module sdm_updown #(
   parameter int TICKS = 81920,
   parameter int CW    = $clog2(TICKS + 1) + 1,
   parameter int TW    = $clog2(TICKS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 tick,
   input  logic                 bit_in,
   output logic signed [CW-1:0] count_nxt,
   output logic                 last
);

   logic signed [CW-1:0] count;
   logic        [TW-1:0] tcnt;
   logic        [CW-1:0] cnt_abs;

   assign count_nxt = !tick ? count :
                      (bit_in ? count + CW'(1) : count - CW'(1));
   assign last      = tick && (tcnt == TW'(TICKS - 1));
   assign cnt_abs   = count[CW-1] ? CW'(-count) : CW'(count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         tcnt  <= '0;
      end else if (clr) begin
         count <= '0;
         tcnt  <= '0;
      end else if (tick) begin
         count <= count_nxt;
         tcnt  <= tcnt + TW'(1);
      end
   end

   // R3: the count can never move further from zero than the samples taken
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_abs <= CW'(tcnt));

   // R3: the window never takes more than TICKS samples
   a_r3_window_limit: assert property (@(posedge clk) disable iff (!rst_n)
      tcnt <= TW'(TICKS));

endmodule

// File: rtl/sdm_scale.sv
module sdm_scale #(
   parameter int TICKS  = 81920,
   parameter int CW     = $clog2(TICKS + 1) + 1,
   parameter int MAG_W  = 14,
   parameter int FRAC_W = 16,
   parameter bit SAT    = 1'b1
) (
   input  logic signed [CW-1:0]    count,
   output logic        [MAG_W+1:0] word
);

   localparam longint unsigned FULL  = 64'd1 << (MAG_W + FRAC_W);
   localparam longint unsigned SCALE = (FULL + longint'(TICKS) - 1) / longint'(TICKS);
   localparam int              SC_W  = MAG_W + FRAC_W + 1;
   localparam int              PW    = CW + SC_W;
   localparam logic [PW-1:0]   MAXV  = PW'((64'd1 << MAG_W) - 1);

   logic [CW-1:0]    mag_in;
   logic [PW-1:0]    prod;
   logic [PW-1:0]    q;
   logic             over;
   logic [MAG_W-1:0] mag_out;

   assign mag_in = count[CW-1] ? CW'(-count) : CW'(count);
   assign prod   = PW'(mag_in) * PW'(SCALE);
   assign q      = prod >> FRAC_W;
   assign over   = q > MAXV;

   generate
      if (SAT) begin : g_clamp
         assign mag_out = over ? {MAG_W{1'b1}} : q[MAG_W-1:0];
      end else begin : g_wrap
         assign mag_out = q[MAG_W-1:0];
      end
   endgenerate

   assign word = {over, count[CW-1], mag_out};

endmodule

// File: rtl/sdm_count_decim.sv
module sdm_count_decim
   import sdm_pkg::*;
#(
   parameter int CONV_TICKS = 81920,
   parameter int MAG_W      = 14,
   parameter int FRAC_W     = 16,
   parameter bit SAT        = 1'b1,
   localparam int WORD_W    = MAG_W + 2,
   localparam int CW        = $clog2(CONV_TICKS + 1) + 1,
   localparam int TW        = $clog2(CONV_TICKS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        div_sel,
   input  logic              bit_in,
   output logic              busy_n,
   output logic [WORD_W-1:0] result
);

   generate
      if (CONV_TICKS < 2) begin : g_bad_ticks
         $error("CONV_TICKS must be at least 2");
      end
      if (MAG_W + FRAC_W > 62) begin : g_bad_frac
         $error("MAG_W + FRAC_W must not exceed 62");
      end
      if (CONV_TICKS > (64'd1 << (MAG_W + FRAC_W))) begin : g_bad_scale
         $error("CONV_TICKS too large for the scaling precision");
      end
   endgenerate

   logic                 running;
   logic                 go;
   div_e                 mode;
   logic                 tick;
   logic                 last;
   logic signed [CW-1:0] count_nxt;
   logic [WORD_W-1:0]    word;

   assign go = start && !running;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         mode    <= DIV_1;
         result  <= '0;
      end else begin
         if (go) begin
            running <= 1'b1;
            mode    <= div_e'(div_sel);
         end else if (last) begin
            running <= 1'b0;
            result  <= word;
         end
      end
   end

   assign busy_n = !running;

   sdm_prescale i_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (go),
      .run   (running),
      .mode  (mode),
      .tick  (tick)
   );

   sdm_updown #(.TICKS(CONV_TICKS), .CW(CW), .TW(TW)) i_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (go),
      .tick      (tick),
      .bit_in    (bit_in),
      .count_nxt (count_nxt),
      .last      (last)
   );

   sdm_scale #(.TICKS(CONV_TICKS), .CW(CW), .MAG_W(MAG_W), .FRAC_W(FRAC_W), .SAT(SAT)) i_scale (
      .count (count_nxt),
      .word  (word)
   );

   // R2: an accepted start request drops busy on the next cycle
   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy_n) |=> !busy_n);

   // R2: the prescaler never produces a sample enable while idle
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      busy_n |-> !tick);

   // R7: the held word only changes as busy returns high
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(busy_n) |-> $stable(result));

   // R4: an overrange word always carries a clamped magnitude
   generate
      if (SAT) begin : g_sat_chk
         a_r4_ovr_clamp: assert property (@(posedge clk) disable iff (!rst_n)
            result[WORD_W-1] |-> (result[MAG_W-1:0] == {MAG_W{1'b1}}));
      end
   endgenerate

endmodule

// File: tb/test_sdm_count_decim.sv
module test_sdm_count_decim;

   localparam int N = 40;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [1:0]  div_sel;
   logic        bit_in;
   logic        busy_n;
   logic [15:0] result;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   sdm_count_decim #(.CONV_TICKS(N)) i_sdm_count_decim (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .div_sel (div_sel),
      .bit_in  (bit_in),
      .busy_n  (busy_n),
      .result  (result)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic pat(input int kind, input int k);
      case (kind)
         0:       return 1'b1;
         1:       return 1'b0;
         2:       return (k % 10) < 7;
         3:       return (k % 2) == 1;
         default: return (k % 10) < 3;
      endcase
   endfunction

   // expected word from R4
   function automatic logic [15:0] exp_word(input int ones);
      longint c, m, sc, q;
      logic ovr;
      c  = 2 * ones - N;
      m  = (c < 0) ? -c : c;
      sc = ((64'd1 << 30) + N - 1) / N;
      q  = (m * sc) >> 16;
      ovr = q > 16383;
      if (ovr) q = 16383;
      return {ovr, c < 0, q[13:0]};
   endfunction

   task automatic run_conv(input string req, input int kind, input logic [1:0] sel,
                           input int poke_start, input int poke_div);
      int d, ones, low;
      logic held;
      logic [15:0] prev;
      logic b;
      d    = (sel == 2'b00) ? 1 : (sel == 2'b01) ? 2 : 4;
      prev = result;
      ones = 0;
      low  = 0;
      held = 1'b1;
      @(negedge clk);
      start   = 1'b1;
      div_sel = sel;
      for (int c = 0; c < d * N; c++) begin
         @(negedge clk);
         start = (c == poke_start);
         if (c == poke_div) div_sel = (sel == 2'b00) ? 2'b10 : 2'b00;
         if (c % d == 0) begin
            b      = pat(kind, c / d);
            bit_in = b;
            ones  += int'(b);
         end
         if (!busy_n) low++;
         if (result !== prev) held = 1'b0;
      end
      @(negedge clk);
      start = 1'b0;
      chk({req, " R2 busy length"}, low, d * N);
      chk({req, " R2 busy released"}, busy_n, 1'b1);
      chk({req, " R3/R4 result"}, result, exp_word(ones));
      chk({req, " R7 held during conversion"}, held, 1'b1);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; start = 1'b0; div_sel = 2'b00; bit_in = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", busy_n, 1'b1);
      chk("R1 result in reset", result, 16'h0000);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 busy idle after reset", busy_n, 1'b1);
      chk("R1 result idle after reset", result, 16'h0000);
   endtask

   task automatic t_full_scale;
      run_conv("R5 ones", 0, 2'b00, -1, -1);
      chk("R5 all ones word", result, 16'hBFFF);
      run_conv("R5 zeros", 1, 2'b01, -1, -1);
      chk("R5 all zeros word", result, 16'hFFFF);
   endtask

   task automatic t_duty;
      run_conv("R4 seven tenths div4", 2, 2'b10, -1, -1);
      chk("R4 seven tenths word", result, 16'h1999);
      run_conv("R4 three tenths div2", 4, 2'b01, -1, -1);
      chk("R4 three tenths word", result, 16'h5999);
   endtask

   task automatic t_balanced;
      run_conv("R9 alternating", 3, 2'b00, -1, -1);
      chk("R9 balanced word", result, 16'h0000);
   endtask

   task automatic t_busy_start;
      run_conv("R6 start while busy", 2, 2'b01, 10, -1);
      chk("R6 word unchanged", result, 16'h1999);
      repeat (5) @(negedge clk);
      chk("R6 no follow-on conversion", busy_n, 1'b1);
   endtask

   task automatic t_div_change;
      run_conv("R8 div change div4", 3, 2'b10, -1, 20);
      run_conv("R8 div change div1", 4, 2'b00, -1, 5);
   endtask

   task automatic t_sel3;
      run_conv("R2 sel 2'b11 as div4", 2, 2'b11, -1, -1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_full_scale();
      t_duty();
      t_balanced();
      t_busy_start();
      t_div_change();
      t_sel3();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule